// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block takes one bit-serial HDLC line, sampled on its own clock under a bit-enable strobe, and turns it back into frames. It finds the opening and closing flag patterns at any bit alignment and accepts two flags that share one zero bit. It drops the zeros that the transmitter inserted after five ones and spots a run of seven ones as an abort. The remaining bits are packed into bytes least-significant bit first. Each frame is checked against its trailing frame check sequence, a reflected CRC whose width, polynomial, preset and residue are parameters. The default setting is the 16-bit CCITT code.

Data bytes leave on a one-cycle strobe, and the first byte of each frame is marked. The check-sequence bytes themselves never appear. Each frame is closed by a one-cycle end pulse that carries a two-bit verdict. Between frames, repeated flags and idle ones produce nothing. After an abort the receiver ignores the line until the next flag.

Top module: `hdlc_rx`

## Requirements
- R1: A 0 bit that arrives after exactly six consecutive 1 bits is a flag, at any bit alignment. The six 1s and the 0 in front of them are not frame data. The flag closes the frame in progress and opens a new one.
- R2: The line pattern 011111101111110 is two flags that share the middle 0. No output is produced between them, and the frame that follows is received normally.
- R3: A 0 that follows exactly five consecutive 1s is removed from the data and from the CRC.
- R4: A 1 that arrives after six or more consecutive 1s is an abort. If the frame has frame content, an end pulse with status 2 (abort) is produced. Frame content means at least one data bit since the last flag, beyond the final seven data bits. The receiver then outputs nothing until a flag is seen.
- R5: Data bits are packed least-significant bit first. Each completed byte is presented with out_valid high for one cycle, and out_sof is high with the first byte presented for a frame.
- R6: The last CRC_W/8 bytes of a frame are never presented on out_byte.
- R7: The end pulse of an octet-aligned frame of at least CRC_W/8+1 bytes carries status 0 (good) when the CRC register, preset to all ones and run over every data bit including the FCS, equals the residue parameter (0xF0B8 for the default CRC-16). Otherwise it carries status 1 (CRC error).
- R8: A frame closed by a flag whose data bit count is not a multiple of 8, or which holds fewer than CRC_W/8+1 bytes, ends with status 3 (length error). No CRC verdict is given for it.
- R9: A flag that closes a frame with no frame content (back-to-back flags) produces no end pulse and no data.
- R10: After reset all outputs are low and the receiver hunts. Line bits before the first flag produce no output.
- R11: A cycle with rx_en low has no effect on the receiver state or the outputs.
- R12: Outputs caused by a line bit appear in the cycle after the bit is sampled, as one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Qualifies rx_bit as a line bit in this cycle |
| rx_bit | input | 1 | Serial line bit |
| out_valid | output | 1 | A data byte is on out_byte this cycle |
| out_byte | output | 8 | Received data byte |
| out_sof | output | 1 | out_byte is the first byte of its frame |
| frm_end | output | 1 | Frame closed this cycle; frm_status is valid |
| frm_status | output | 2 | 0 good, 1 CRC error, 2 abort, 3 length error |

## Verification
The bench checks the shared-zero flag pair. A receiver that needs a fresh 0 before each flag would turn the second flag into data and corrupt or lengthen the next frame. It sends payload and check bytes that force stuffing next to the closing flag, such as 0x1F and 0xF8. A design that miscounts the run there would report a false abort or a CRC error. It also covers runs of flags, idle ones after a flag, aborts of short and long frames, data sent while hunting, non-octet and one-byte frames, and bit-enable gaps. These catch designs that emit empty frames or report aborts with no content. They also catch designs that leak bytes while hunting, present the FCS bytes, or let an idle cycle shift state.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // Number of trailing data bits held back so that a flag's prefix is never taken as data.
  localparam int unsigned FLAG_PREFIX = 7;

  typedef enum logic [1:0] {
    ST_GOOD  = 2'd0,
    ST_CRC   = 2'd1,
    ST_ABORT = 2'd2,
    ST_LEN   = 2'd3
  } frm_stat_e;

  // One step of a right-shifting (reflected) CRC; widths up to 32 bits, unused upper bits zero.
  function automatic logic [31:0] crc_bit(input logic [31:0] crc, input logic din,
                                          input logic [31:0] poly);
    logic fb;
    fb = crc[0] ^ din;
    return (crc >> 1) ^ (fb ? poly : 32'd0);
  endfunction

  // Frame verdict at a closing flag.
  function automatic frm_stat_e judge(input logic octet_ok, input logic long_ok,
                                      input logic crc_ok);
    if (!octet_ok || !long_ok) return ST_LEN;
    if (!crc_ok) return ST_CRC;
    return ST_GOOD;
  endfunction

endpackage

// File: rtl/hdlc_rx_linedec.sv
module hdlc_rx_linedec (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_data
);
  logic [2:0] ones_q;
  logic       ev_stuff;

  always_comb begin
    ev_flag  = bit_en & ~bit_in & (ones_q == 3'd6);
    ev_abort = bit_en &  bit_in & (ones_q >= 3'd6);
    ev_stuff = bit_en & ~bit_in & (ones_q == 3'd5);
    ev_data  = bit_en & ~ev_flag & ~ev_abort & ~ev_stuff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= 3'd0;
    end else if (bit_en) begin
      if (bit_in) ones_q <= (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
      else        ones_q <= 3'd0;
    end
  end

  // R11: an idle cycle leaves the run length untouched
  assert_idle_holds_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ones_q));

endmodule

// File: rtl/hdlc_rx_dly.sv
module hdlc_rx_dly #(
  parameter int unsigned DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic din,
  output logic cvld,
  output logic cbit
);
  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  logic [DEPTH-1:0] sr_q;
  logic [FW-1:0]    fill_q;

  assign cvld = push & ~clr & (fill_q == FULL);
  assign cbit = sr_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (push) begin
      sr_q <= {sr_q[DEPTH-2:0], din};
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end

  // R1: the bits in front of a flag never reach the framer
  assert_clear_drains_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !cvld);

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned CRC_W     = 16,
  parameter logic [31:0] CRC_POLY  = 32'h0000_8408,
  parameter logic [31:0] CRC_INIT  = 32'h0000_FFFF,
  parameter logic [31:0] CRC_MAGIC = 32'h0000_F0B8,
  parameter int unsigned FCS_BYTES = CRC_W / 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_flag,
  input  logic       ev_abort,
  input  logic       cvld,
  input  logic       cbit,
  output logic       hunting,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_sof,
  output logic       frm_end,
  output logic [1:0] frm_status
);
  localparam logic [31:0] MASK   = (CRC_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CRC_W) - 32'd1);
  localparam logic [31:0] POLY_M = CRC_POLY & MASK;
  localparam int unsigned BC_W   = $clog2(FCS_BYTES + 2);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(FCS_BYTES + 1);
  localparam int unsigned BF_W   = $clog2(FCS_BYTES + 1);
  localparam logic [BF_W-1:0] BF_FULL = BF_W'(FCS_BYTES);

  logic             hunt_q, any_q, sof_pend_q;
  logic [2:0]       bitc_q;
  logic [BC_W-1:0]  bytec_q;
  logic [BF_W-1:0]  bfill_q;
  logic [7:0]       sh_q;
  logic [CRC_W-1:0] crc_q;
  logic [7:0]       bq_q [FCS_BYTES];

  logic       restart, byte_done, crc_ok;
  logic [7:0] byte_new;
  frm_stat_e  verdict;

  assign hunting   = hunt_q;
  assign restart   = ev_flag | ev_abort;
  assign byte_new  = {cbit, sh_q[7:1]};
  assign byte_done = cvld & (bitc_q == 3'd7);
  assign crc_ok    = (crc_q == CRC_MAGIC[CRC_W-1:0]);
  assign verdict   = judge(bitc_q == 3'd0, bytec_q == BC_MAX, crc_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunt_q     <= 1'b1;
      any_q      <= 1'b0;
      sof_pend_q <= 1'b1;
      bitc_q     <= '0;
      bytec_q    <= '0;
      bfill_q    <= '0;
      sh_q       <= '0;
      crc_q      <= CRC_INIT[CRC_W-1:0];
      for (int i = 0; i < FCS_BYTES; i++) bq_q[i] <= '0;
      out_valid  <= 1'b0;
      out_byte   <= '0;
      out_sof    <= 1'b0;
      frm_end    <= 1'b0;
      frm_status <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      frm_end   <= 1'b0;
      if (restart) begin
        if (!hunt_q && any_q) begin
          frm_end    <= 1'b1;
          frm_status <= ev_abort ? ST_ABORT : verdict;
        end
        hunt_q     <= ev_abort;
        any_q      <= 1'b0;
        sof_pend_q <= 1'b1;
        bitc_q     <= '0;
        bytec_q    <= '0;
        bfill_q    <= '0;
        crc_q      <= CRC_INIT[CRC_W-1:0];
      end else if (cvld) begin
        any_q  <= 1'b1;
        sh_q   <= byte_new;
        bitc_q <= bitc_q + 3'd1;
        crc_q  <= CRC_W'(crc_bit(32'(crc_q), cbit, POLY_M));
        if (byte_done) begin
          if (bytec_q != BC_MAX) bytec_q <= bytec_q + 1'b1;
          for (int i = 0; i < FCS_BYTES - 1; i++) bq_q[i] <= bq_q[i+1];
          bq_q[FCS_BYTES-1] <= byte_new;
          if (bfill_q == BF_FULL) begin
            out_valid  <= 1'b1;
            out_byte   <= bq_q[0];
            out_sof    <= sof_pend_q;
            sof_pend_q <= 1'b0;
          end else begin
            bfill_q <= bfill_q + 1'b1;
          end
        end
      end
    end
  end

  // R4: while hunting, nothing leaves the block until a flag arrives
  assert_hunt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_q && !ev_flag) |=> (!out_valid && !frm_end));
  // R5: the start marker only travels with a byte
  assert_sof_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R9: a frame end is followed by a fresh, empty frame
  assert_end_then_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> (!frm_end && !out_valid));
  // R12: outputs are single-cycle pulses
  assert_byte_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned CRC_W     = 16,
  parameter logic [31:0] CRC_POLY  = 32'h0000_8408,
  parameter logic [31:0] CRC_INIT  = 32'h0000_FFFF,
  parameter logic [31:0] CRC_MAGIC = 32'h0000_F0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_bit,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_sof,
  output logic       frm_end,
  output logic [1:0] frm_status
);
  localparam int unsigned FCS_BYTES = CRC_W / 8;

  logic ev_flag, ev_abort, ev_data;
  logic hunting, cvld, cbit;

  hdlc_rx_linedec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (rx_en),
    .bit_in   (rx_bit),
    .ev_flag  (ev_flag),
    .ev_abort (ev_abort),
    .ev_data  (ev_data)
  );

  hdlc_rx_dly #(.DEPTH(FLAG_PREFIX)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_flag | ev_abort | hunting),
    .push  (ev_data),
    .din   (rx_bit),
    .cvld  (cvld),
    .cbit  (cbit)
  );

  hdlc_rx_framer #(
    .CRC_W     (CRC_W),
    .CRC_POLY  (CRC_POLY),
    .CRC_INIT  (CRC_INIT),
    .CRC_MAGIC (CRC_MAGIC),
    .FCS_BYTES (FCS_BYTES)
  ) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_flag    (ev_flag),
    .ev_abort   (ev_abort),
    .cvld       (cvld),
    .cbit       (cbit),
    .hunting    (hunting),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_sof    (out_sof),
    .frm_end    (frm_end),
    .frm_status (frm_status)
  );

  // R10: no bit is committed to a frame while the receiver hunts
  assert_commit_outside_hunt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cvld |-> !hunting);

endmodule

// File: tb/tb_hdlc_rx.sv
module tb_hdlc_rx;
  localparam int FCS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_bit = 1'b0;
  logic       out_valid, out_sof, frm_end;
  logic [7:0] out_byte;
  logic [1:0] frm_status;

  always #2 clk = ~clk;  // 250 MHz

  hdlc_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
    .frm_end(frm_end), .frm_status(frm_status)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int n_stat [4];
  int n_bytes = 0;
  int tx_ones = 0;
  bit gap_mode = 0;

  // reference model state
  bit         m_hunt = 1;
  int         m_ones = 0;
  bit         m_pend [$];
  int         m_bits = 0;
  logic [7:0] m_cur = 0;
  logic [7:0] m_bytes [$];
  logic       e_valid = 0, e_sof = 0, e_end = 0;
  logic [7:0] e_byte = 0;
  logic [1:0] e_stat = 0;

  function automatic logic [15:0] crc16(input logic [7:0] d [$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = (c[0] ^ d[i][k]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] finish_status();
    int n = m_bytes.size();
    logic [15:0] c;
    if ((m_bits % 8) != 0 || n < FCS + 1) return 2'd3;   // R8
    c = crc16(m_bytes, n - FCS) ^ 16'hFFFF;
    return (c == {m_bytes[n-1], m_bytes[n-2]}) ? 2'd0 : 2'd1; // R7
  endfunction

  function automatic void m_clear();
    m_pend.delete(); m_bytes.delete(); m_bits = 0; m_cur = 0;
  endfunction

  function automatic void model(input logic en, input logic b);
    e_valid = 0; e_sof = 0; e_end = 0;
    if (!en) return;                                       // R11
    if (!b && m_ones == 6) begin                           // R1 flag
      if (!m_hunt && m_bits > 0) begin e_end = 1; e_stat = finish_status(); end
      m_clear(); m_hunt = 0; m_ones = 0;
    end else if (b && m_ones >= 6) begin                   // R4 abort
      if (!m_hunt && m_bits > 0) begin e_end = 1; e_stat = 2'd2; end
      m_clear(); m_hunt = 1; m_ones = 7;
    end else if (!b && m_ones == 5) begin                  // R3 stuffed zero
      m_ones = 0;
    end else begin
      if (!m_hunt) begin
        m_pend.push_back(b);
        if (m_pend.size() > 7) begin
          bit c = m_pend.pop_front();
          m_cur[m_bits % 8] = c;                           // R5 LSB first
          m_bits++;
          if (m_bits % 8 == 0) begin
            m_bytes.push_back(m_cur);
            m_cur = 0;
            if (m_bytes.size() > FCS) begin                // R6 withhold FCS
              int idx = m_bytes.size() - 1 - FCS;
              e_valid = 1; e_byte = m_bytes[idx]; e_sof = (idx == 0);
            end
          end
        end
      end
      m_ones = b ? ((m_ones >= 7) ? 7 : m_ones + 1) : 0;
    end
  endfunction

  // one bus cycle: check what the previous bit produced (R12), then drive and model
  task automatic cyc(input logic en, input logic b);
    @(negedge clk);
    if (frm_end) n_stat[frm_status]++;
    if (out_valid) n_bytes++;
    chk({out_valid, out_sof, frm_end} === {e_valid, e_sof, e_end} &&
        (!e_valid || out_byte === e_byte) && (!e_end || frm_status === e_stat),
        e_end ? "R7/R8/R4 end" : (e_valid ? "R5/R6 byte" : "R9/R12 quiet"),
        {out_valid, out_sof, frm_end, frm_status, out_byte},
        {e_valid, e_sof, e_end, e_stat, e_byte});
    rx_en = en; rx_bit = b;
    model(en, b);
  endtask

  task automatic line_bit(input logic b);
    if (gap_mode) cyc(1'b0, ~b);                           // R11 idle cycle with junk
    cyc(1'b1, b);
  endtask

  task automatic tx_bit(input logic b);
    line_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin line_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_bit(v[i]);
  endtask

  task automatic tx_flag();
    line_bit(1'b0);
    for (int i = 0; i < 6; i++) line_bit(1'b1);
    line_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic tx_frame(input logic [7:0] d [$], input bit corrupt);
    logic [15:0] c = crc16(d, d.size()) ^ 16'hFFFF;
    for (int i = 0; i < d.size(); i++) tx_byte((corrupt && i == 0) ? d[i] ^ 8'h01 : d[i]);
    tx_byte(c[7:0]);
    tx_byte(c[15:8]);
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);
  endtask

  initial begin
    int g0, b0;
    for (int i = 0; i < 4; i++) n_stat[i] = 0;
    // R10: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({out_valid, out_sof, frm_end} == 3'b000, "R10 reset outputs", {out_valid, out_sof, frm_end}, 0);
    end
    rst_n = 1'b1;

    // R10: noise and idle before any flag, then R1 misaligned flag
    line_bit(1); line_bit(0); line_bit(1);
    for (int i = 0; i < 10; i++) line_bit(1);
    line_bit(0); line_bit(1); line_bit(1);
    tx_flag();
    settle();
    chk(n_bytes == 0 && n_stat[0] + n_stat[1] + n_stat[2] + n_stat[3] == 0, "R10 hunt before flag", n_bytes, 0);

    // R1/R7/R6: good frame, four data bytes out
    b0 = n_bytes;
    tx_frame('{8'h11, 8'h22, 8'h33, 8'hC4}, 0); tx_flag(); settle();
    chk(n_stat[0] == 1, "R7 good frame", n_stat[0], 1);
    chk(n_bytes - b0 == 4, "R6 fcs withheld", n_bytes - b0, 4);

    // R2: shared-zero second flag, then a stuffing-heavy frame (R3)
    for (int i = 0; i < 6; i++) line_bit(1'b1);
    line_bit(1'b0);
    tx_ones = 0;
    tx_frame('{8'hA5, 8'hFF, 8'h7E, 8'h3E, 8'hF8}, 0); tx_flag(); settle();
    chk(n_stat[0] == 2, "R2 R3 frame after shared flag", n_stat[0], 2);

    // R9: back-to-back flags
    g0 = n_stat[0] + n_stat[1] + n_stat[2] + n_stat[3];
    tx_flag(); tx_flag(); tx_flag(); settle();
    chk(n_stat[0] + n_stat[1] + n_stat[2] + n_stat[3] == g0, "R9 no empty frames", n_stat[0] + n_stat[1] + n_stat[2] + n_stat[3], g0);

    // R7: corrupted frame
    tx_frame('{8'h01, 8'h02, 8'h03}, 1); tx_flag(); settle();
    chk(n_stat[1] == 1, "R7 crc error", n_stat[1], 1);

    // R8: non-octet and short frames
    tx_frame('{8'h10, 8'h20, 8'h30}, 0); tx_bit(1); tx_bit(0); tx_bit(1); tx_flag(); settle();
    tx_byte(8'h55); tx_flag(); settle();
    chk(n_stat[3] == 2, "R8 length errors", n_stat[3], 2);

    // R4: abort mid-frame, data while hunting ignored, then recovery
    tx_byte(8'h3E); tx_byte(8'hF8); tx_byte(8'h1F);
    for (int i = 0; i < 8; i++) line_bit(1'b1);
    tx_ones = 0;
    b0 = n_bytes;
    tx_byte(8'h12); tx_byte(8'h34); settle();
    chk(n_stat[2] == 1, "R4 abort reported", n_stat[2], 1);
    chk(n_bytes == b0, "R4 hunting silent", n_bytes - b0, 0);
    tx_flag();
    tx_frame('{8'h1F, 8'h9F, 8'h3F, 8'hEF}, 0); tx_flag(); settle();
    chk(n_stat[0] == 3, "R4 recovery good frame", n_stat[0], 3);

    // R4: idle ones right after a flag are not a reportable abort
    for (int i = 0; i < 12; i++) line_bit(1'b1);
    tx_flag(); settle();
    chk(n_stat[2] == 1, "R4 idle not reported", n_stat[2], 1);

    // R11: gaps between bits change nothing
    gap_mode = 1;
    tx_frame('{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00}, 0); tx_flag();
    gap_mode = 0;
    settle();
    chk(n_stat[0] == 4, "R11 gapped good frame", n_stat[0], 4);
    chk(n_stat[1] == 1, "R7 no extra crc errors", n_stat[1], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule